// File: doc/BRIEF.md
# Serial-Clocked EEPROM Word Store

This block is a synthesizable stand-in for a small serial EEPROM organised as sixteen-bit words. A host drives a select line, a serial clock and a serial data input, and reads a serial data output. The block runs on a faster system clock. It oversamples the serial clock and acts on each rising edge while select is high. A command is framed as a start bit, a two-bit opcode and a word address. A programming command that carries data is followed by sixteen data bits. The block decodes read, single-word write, single-word erase, erase of the whole array, fill of the whole array with one value, and the latch commands that enable and disable programming.

A latch gates every programming command. The latch starts cleared. A programming command that is accepted starts a busy period, which lasts a parameterised number of system clocks. After the host deselects the block and selects it again, the data output reports whether programming is still in progress. The `ADDR_W` parameter sets the address width: six bits gives 64 words and eight bits gives 256 words.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset every word reads 16'hFFFF, and the programming-enable latch is cleared, so a write sent before any enable command leaves its word unchanged.
- R2: While select is high, the block samples data in on each serial clock rising edge. Zeros before the first 1 are ignored. A command is a start bit of 1, then a two-bit opcode (10 read, 01 write, 11 erase, 00 special), then ADDR_W address bits MSB first.
- R3: A read presents a 0 on data out after the last address bit. Each following serial clock rising edge then moves data out to the next bit of the addressed word, MSB first.
- R4: A write (opcode 01) takes sixteen data bits MSB first after the address. When programming is enabled, those bits replace the addressed word.
- R5: An erase (opcode 11) sets the addressed word to 16'hFFFF when programming is enabled.
- R6: Opcode 00 with the top two address bits 10 sets every word to 16'hFFFF when programming is enabled.
- R7: Opcode 00 with the top two address bits 01 takes sixteen data bits and writes them to every word when programming is enabled.
- R8: Opcode 00 with the top two address bits 11 sets the enable latch, and 00 clears it; the remaining address bits are ignored. While the latch is clear, every programming command leaves all words unchanged and starts no busy period.
- R9: Deselecting returns the block to waiting for a start bit. A partly received command has no effect, and data out is 0 while select is low.
- R10: An accepted programming command starts a busy period of BUSY_CYC system clocks. While select is high and the block is waiting for a start bit, data out is 0 during that period and 1 otherwise. A start bit is not accepted while the block is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also times the busy period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Select, active high |
| sk | input | 1 | Serial clock from the host, oversampled by clk |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out: read bits, or the ready status while waiting |

## Verification
Directed sequences come first. Reads of fresh words separate the erased reset contents from a zero-reset array. A write sent before any enable command shows whether the latch gates programming. A command cut short by deselecting shows whether partial frames are discarded. The array-wide erase and fill are read back at the first, last and a middle address, which separates whole-array operations from single-word ones. Seeded random writes, erases and reads at random addresses follow, each checked against a model array in the bench, so that wrong address order or wrong data bit order shows as a mismatch. Leading zeros before a start bit and the status output read right after a write, and again after the busy period, separate the framing and busy logic from the data path.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OPC  = 3'd1,
    ST_ADDR = 3'd2,
    ST_DATA = 3'd3,
    ST_READ = 3'd4,
    ST_DONE = 3'd5
  } uwire_state_e;

  // Opcode values as they arrive on the wire
  localparam logic [1:0] OPC_SPEC  = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  // Sub-codes carried in the top two address bits of opcode 00
  localparam logic [1:0] SUB_LOCK  = 2'b00;
  localparam logic [1:0] SUB_FILL  = 2'b01;
  localparam logic [1:0] SUB_WIPE  = 2'b10;
  localparam logic [1:0] SUB_ARM   = 2'b11;

endpackage

// File: rtl/uwire_word_array.sv
module uwire_word_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_one,
  input  logic          prog_all,
  input  logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];
  logic [WORDS-1:0] word_en;

  // Per-word clock enable: targeted hit or array-wide operation
  for (genvar g = 0; g < WORDS; g++) begin : g_en
    assign word_en[g] = prog_all | (prog_one & (prog_addr == AW'(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (word_en[i]) mem_q[i] <= prog_data;
      end
    end
  end

  assign rd_word = mem_q[rd_addr];

  // Single-word and whole-array requests are mutually exclusive
  assert_one_or_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_one, prog_all}));

  // A single-word request reaches exactly one word enable
  assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_one && !prog_all) |-> ($countones(word_en) == 1));

endmodule

// File: rtl/uwire_prog_timer.sv
module uwire_prog_timer #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int TW = $clog2(CYC + 1);
  localparam logic [TW-1:0] LOAD = TW'(CYC);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start | (cnt_q != '0);
    cnt_d  = start ? LOAD : (cnt_q - TW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  assert_busy_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);

  assert_start_sets_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/uwire_cmd_fsm.sv
module uwire_cmd_fsm
  import uwire_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sk_rise,
  input  logic          di,
  input  logic          busy,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] rd_addr,
  output logic          prog_one,
  output logic          prog_all,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          wen,
  output logic          dout
);

  localparam int MAXF  = (AW > DW) ? AW : DW;
  localparam int CNT_W = $clog2(MAXF + 1);
  localparam logic [CNT_W-1:0] LAST_OPC  = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(AW - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DW - 1);

  uwire_state_e      state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        opc_q, opc_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [DW-1:0]     data_q, data_d;
  logic [DW:0]       rsh_q, rsh_d;
  logic              wen_q, wen_d;

  logic [AW-1:0]     addr_shift;
  logic [DW-1:0]     data_shift;
  logic [1:0]        sub_code;

  assign addr_shift = {addr_q[AW-2:0], di};
  assign data_shift = {data_q[DW-2:0], di};
  assign sub_code   = addr_shift[AW-1 -: 2];
  assign rd_addr    = addr_shift;
  assign prog_addr  = (state_q == ST_ADDR) ? addr_shift : addr_q;

  // Next-state and command decode
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    opc_d     = opc_q;
    addr_d    = addr_q;
    data_d    = data_q;
    rsh_d     = rsh_q;
    wen_d     = wen_q;
    prog_one  = 1'b0;
    prog_all  = 1'b0;
    prog_data = '1;

    if (!cs) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (sk_rise) begin
      unique case (state_q)
        ST_IDLE: begin
          if (di && !busy) begin
            state_d = ST_OPC;
            cnt_d   = '0;
          end
        end
        ST_OPC: begin
          opc_d = {opc_q[0], di};
          if (cnt_q == LAST_OPC) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_ADDR: begin
          addr_d = addr_shift;
          if (cnt_q == LAST_ADDR) begin
            cnt_d   = '0;
            state_d = ST_DONE;
            unique case (opc_q)
              OPC_READ: begin
                rsh_d   = {1'b0, rd_word};
                state_d = ST_READ;
              end
              OPC_WRITE: state_d = ST_DATA;
              OPC_ERASE: prog_one = wen_q;
              default: begin
                unique case (sub_code)
                  SUB_ARM:  wen_d    = 1'b1;
                  SUB_LOCK: wen_d    = 1'b0;
                  SUB_WIPE: prog_all = wen_q;
                  default:  state_d  = ST_DATA;
                endcase
              end
            endcase
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_DATA: begin
          data_d = data_shift;
          if (cnt_q == LAST_DATA) begin
            prog_data = data_shift;
            if (opc_q == OPC_WRITE) prog_one = wen_q;
            else                    prog_all = wen_q;
            cnt_d   = '0;
            state_d = ST_DONE;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_READ: rsh_d = {rsh_q[DW-1:0], 1'b0};
        default: ;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      opc_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rsh_q   <= '0;
      wen_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      opc_q   <= opc_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      rsh_q   <= rsh_d;
      wen_q   <= wen_d;
    end
  end

  assign wen = wen_q;

  always_comb begin
    dout = 1'b0;
    if (cs) begin
      if (state_q == ST_READ)      dout = rsh_q[DW];
      else if (state_q == ST_IDLE) dout = ~busy;
    end
  end

  assert_deselect_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (state_q == ST_IDLE));

  assert_read_lead_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_READ) |-> !dout);

endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);

  logic              sk_q;
  logic              sk_rise;
  logic              busy;
  logic              prog_one;
  logic              prog_all;
  logic              prog_start;
  logic              wen;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] prog_addr;
  logic [DATA_W-1:0] prog_data;
  logic [DATA_W-1:0] rd_word;

  // Serial clock edge detect on the system clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_q <= 1'b0;
    else        sk_q <= sk;
  end
  assign sk_rise    = sk & ~sk_q;
  assign prog_start = prog_one | prog_all;

  uwire_cmd_fsm #(.AW(ADDR_W), .DW(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .sk_rise   (sk_rise),
    .di        (di),
    .busy      (busy),
    .rd_word   (rd_word),
    .rd_addr   (rd_addr),
    .prog_one  (prog_one),
    .prog_all  (prog_all),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .wen       (wen),
    .dout      (dout)
  );

  uwire_word_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_one  (prog_one),
    .prog_all  (prog_all),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .rd_addr   (rd_addr),
    .rd_word   (rd_word)
  );

  uwire_prog_timer #(.CYC(BUSY_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (prog_start),
    .busy  (busy)
  );

  assert_prog_needs_wen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> wen);

  assert_no_start_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !busy);

  assert_deselect_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !dout);

endmodule

// File: tb/test_uwire_eeprom.sv
module test_uwire_eeprom;

  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int WORDS = 1 << AW;
  localparam int BUSY  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sk = 1'b0;
  logic di = 1'b0;
  logic dout;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [DW-1:0] model [WORDS];

  always #2.5 clk = ~clk;

  uwire_eeprom #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYC(BUSY)) i_uwire_eeprom (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] sub_addr(input logic [1:0] code);
    return {code, {(AW-2){1'b0}}};
  endfunction

  task automatic sel();
    @(negedge clk); cs = 1'b1; sk = 1'b0; di = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk); cs = 1'b0; sk = 1'b0; di = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk); di = b; sk = 1'b0;
    repeat (2) @(negedge clk);
    sk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [AW-1:0] a);
    bit_out(1'b1);
    bit_out(op[1]); bit_out(op[0]);
    for (int i = AW-1; i >= 0; i--) bit_out(a[i]);
  endtask

  task automatic read_word(input logic [AW-1:0] a, input int lead, output logic [DW:0] v);
    sel();
    for (int i = 0; i < lead; i++) bit_out(1'b0);
    send_cmd(2'b10, a);
    v = '0;
    for (int i = 0; i <= DW; i++) begin
      @(negedge clk); sk = 1'b0;
      repeat (2) @(negedge clk);
      v = {v[DW-1:0], dout};
      sk = 1'b1;
      repeat (2) @(negedge clk);
    end
    desel();
  endtask

  task automatic wait_ready();
    sel();
    for (int i = 0; i < 200; i++) begin
      if (dout) break;
      @(negedge clk);
    end
    desel();
  endtask

  task automatic prog(input logic [1:0] op, input logic [AW-1:0] a,
                      input bit has_data, input logic [DW-1:0] d);
    sel();
    send_cmd(op, a);
    if (has_data) for (int i = DW-1; i >= 0; i--) bit_out(d[i]);
    desel();
    wait_ready();
  endtask

  task automatic expect_word(input string req, input logic [AW-1:0] a);
    logic [DW:0] v;
    read_word(a, 0, v);
    check(req, {15'd0, v}, {15'd0, 1'b0, model[a]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [DW:0] v;
    int unsigned seed;
    int cnt;
    seed = $urandom(32'd2024);
    for (int i = 0; i < WORDS; i++) model[i] = '1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: deselected output quiet; R10: idle ready shows 1
    check("R9 dout low while deselected", {31'd0, dout}, 32'd0);
    sel();
    check("R10 idle ready", {31'd0, dout}, 32'd1);
    desel();

    // R1: erased contents after reset
    expect_word("R1 word 0 after reset", 0);
    expect_word("R1 last word after reset", AW'(WORDS-1));

    // R1/R8: write before enable is blocked, no busy period
    sel(); send_cmd(2'b01, 6'd5);
    for (int i = DW-1; i >= 0; i--) bit_out(1'b0);
    desel(); sel();
    check("R8 no busy when disabled", {31'd0, dout}, 32'd1);
    desel();
    expect_word("R1 write blocked before enable", 6'd5);

    // R8: enable (low address bits are don't-care)
    prog(2'b00, sub_addr(2'b11) | 6'h0B, 0, '0);

    // R4/R10: write with status observation
    sel(); send_cmd(2'b01, 6'd5);
    for (int i = DW-1; i >= 0; i--) bit_out(((16'h1234 >> i) & 1) != 0);
    desel(); sel();
    check("R10 busy right after write", {31'd0, dout}, 32'd0);
    cnt = 0;
    while (!dout && cnt < 100) begin @(negedge clk); cnt++; end
    check("R10 ready after busy period", {31'd0, dout}, 32'd1);
    check("R10 busy period not overlong", {31'd0, cnt <= BUSY}, 32'd1);
    desel();
    model[5] = 16'h1234;
    expect_word("R4 directed write", 6'd5);

    // R2: leading zeros before the start bit
    read_word(6'd5, 3, v);
    check("R2 leading zeros ignored", {15'd0, v}, {15'd0, 1'b0, 16'h1234});
    check("R3 dummy zero first", {31'd0, v[DW]}, 32'd0);

    // R5: directed erase
    prog(2'b01, 6'd12, 1, 16'h00FF); model[12] = 16'h00FF;
    expect_word("R4 write before erase", 6'd12);
    prog(2'b11, 6'd12, 0, '0); model[12] = '1;
    expect_word("R5 erase sets ones", 6'd12);

    // Random mix of writes, erases and reads
    for (int n = 0; n < 60; n++) begin
      int op;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      op = $urandom % 4;
      a  = AW'($urandom);
      d  = DW'($urandom);
      if (op < 2) begin
        prog(2'b01, a, 1, d); model[a] = d;
        expect_word("R4 random write", a);
      end else if (op == 2) begin
        expect_word("R3 random read", a);
      end else begin
        prog(2'b11, a, 0, '0); model[a] = '1;
        expect_word("R5 random erase", a);
      end
    end

    // R9: abort in the middle of a write's data
    prog(2'b01, 6'd9, 1, 16'h5555); model[9] = 16'h5555;
    sel(); send_cmd(2'b01, 6'd9);
    for (int i = 0; i < 8; i++) bit_out(1'b1);
    desel();
    expect_word("R9 aborted write no effect", 6'd9);

    // R7: fill all words
    prog(2'b00, sub_addr(2'b01), 1, 16'hA5C3);
    for (int i = 0; i < WORDS; i++) model[i] = 16'hA5C3;
    expect_word("R7 fill word 0", 6'd0);
    expect_word("R7 fill middle", 6'd33);
    expect_word("R7 fill last", AW'(WORDS-1));

    // R6: wipe all words
    prog(2'b00, sub_addr(2'b10), 0, '0);
    for (int i = 0; i < WORDS; i++) model[i] = '1;
    expect_word("R6 wipe word 0", 6'd0);
    expect_word("R6 wipe middle", 6'd20);
    expect_word("R6 wipe last", AW'(WORDS-1));

    // R8: disable, then programming is blocked
    prog(2'b00, sub_addr(2'b00) | 6'h07, 0, '0);
    sel(); send_cmd(2'b01, 6'd7);
    for (int i = DW-1; i >= 0; i--) bit_out(((16'h0F0F >> i) & 1) != 0);
    desel(); sel();
    check("R8 no busy after disable", {31'd0, dout}, 32'd1);
    desel();
    expect_word("R8 write blocked after disable", 6'd7);
    prog(2'b00, sub_addr(2'b01), 1, 16'h0000);
    expect_word("R8 fill blocked after disable", 6'd40);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule